// File: doc/BRIEF.md
# Packet Queue with Reserve/Commit Windows

The block keeps track of where packets are in a queue of fixed-size packet slots. The packet payload lives in an external RAM, and this block only hands out slot indices. A producer asks for a window of one to `MAXWIN` contiguous free slots. The grant and the first slot index come back in the same cycle. The producer fills those slots in place and then commits the window by quoting its first slot index as a tag. From that point consumers can see the packets. A consumer works the same way on the other side: it reserves a window of contiguous available packets, reads them in place, and commits the window so that its slots return to free storage. A reserved window belongs to its requester alone until the matching commit arrives.

A mode input selects how windows are released. In ordered mode the queue behaves as a strict ring. A window that is committed before an older window on the same side stays invisible (producer side) or unreclaimed (consumer side). It is released, together with every committed run behind it, once the older window commits. In unordered mode a commit takes effect on its own, and a reserve takes the lowest-numbered run of suitable slots wherever that run lies. The capacity is a hard limit. A reserve of a legal length that cannot be satisfied is refused and raises an overflow pulse.

Top module: `pkt_window_queue`

## Requirements
- R1: After reset every slot is free. The outputs read `n_free` = DEPTH, `n_avail` = 0, `n_resv` = 0, `full` = 0 and `empty` = 1.
- R2: A producer reserve with length 1..MAXWIN that fits raises `p_gnt` in the same cycle, and `p_base` gives the first slot. In ordered mode the window starts at the slot after the previous producer window, with indices wrapping modulo DEPTH.
- R3: A producer reserve with a legal length that does not fit gives `p_gnt` = 0 and `p_ovf` = 1 in that cycle, and the queue state does not change. A length of 0 or more than MAXWIN gives neither a grant nor an overflow, on either side.
- R4: A consumer reserve is granted only when `c_len` contiguous slots are available. In ordered mode the window starts at the oldest available packet that is not yet reserved. Otherwise `c_gnt` = 0.
- R5: A producer commit makes its slots available from the next cycle. In ordered mode the slots stay hidden while an older producer window is still uncommitted, and they are released together with it when it commits.
- R6: A consumer commit returns its slots to free storage from the next cycle. In ordered mode the slots stay unreclaimed while an older consumer window is still uncommitted.
- R7: A commit whose tag is not the first slot of an outstanding window on that side is ignored.
- R8: In unordered mode a commit takes effect immediately, whatever older windows are still open. A reserve takes the lowest starting slot whose run of `len` slots, wrapping modulo DEPTH, is entirely free (producer) or entirely available (consumer).
- R9: `full` is 1 exactly when `n_free` = 0, and `empty` is 1 exactly when `n_avail` = 0. `n_resv` counts every slot that is neither free nor available, which includes committed slots that are held back.
- R10: A reserve and a commit in the same cycle, on the same side or on opposite sides, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_unordered | input | 1 | 1 selects unordered release. Change it only while the queue is idle |
| p_req | input | 1 | Producer reserve request |
| p_len | input | $clog2(MAXWIN+1) | Producer window length in packets |
| p_gnt | output | 1 | Producer reserve granted (combinational) |
| p_base | output | $clog2(DEPTH) | First slot of the producer window |
| p_ovf | output | 1 | Producer reserve refused for lack of space |
| p_cmt | input | 1 | Producer commit |
| p_tag | input | $clog2(DEPTH) | First slot of the producer window being committed |
| c_req | input | 1 | Consumer reserve request |
| c_len | input | $clog2(MAXWIN+1) | Consumer window length in packets |
| c_gnt | output | 1 | Consumer reserve granted (combinational) |
| c_base | output | $clog2(DEPTH) | First slot of the consumer window |
| c_cmt | input | 1 | Consumer commit |
| c_tag | input | $clog2(DEPTH) | First slot of the consumer window being committed |
| n_free | output | $clog2(DEPTH+1) | Free slots |
| n_resv | output | $clog2(DEPTH+1) | Slots that are neither free nor available |
| n_avail | output | $clog2(DEPTH+1) | Packets visible to consumers |
| full | output | 1 | No free slot |
| empty | output | 1 | No available packet |

## Verification
A reserve and a commit can land in the same cycle. The bench provokes this in two ways. It commits an older producer window in the same cycle that a new window is reserved at the wrapped ring position. It also pairs a consumer commit with a refused producer reserve while the queue is full. Each case is judged in the following cycle through the granted base and the free and available counts: the new window must appear, and the whole held-back run must be released.

// File: rtl/pkt_window_queue.sv
module pkt_window_queue #(
  parameter int DEPTH  = 8,
  parameter int MAXWIN = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_unordered,
  input  logic                          p_req,
  input  logic [$clog2(MAXWIN+1)-1:0]   p_len,
  output logic                          p_gnt,
  output logic [$clog2(DEPTH)-1:0]      p_base,
  output logic                          p_ovf,
  input  logic                          p_cmt,
  input  logic [$clog2(DEPTH)-1:0]      p_tag,
  input  logic                          c_req,
  input  logic [$clog2(MAXWIN+1)-1:0]   c_len,
  output logic                          c_gnt,
  output logic [$clog2(DEPTH)-1:0]      c_base,
  input  logic                          c_cmt,
  input  logic [$clog2(DEPTH)-1:0]      c_tag,
  output logic [$clog2(DEPTH+1)-1:0]    n_free,
  output logic [$clog2(DEPTH+1)-1:0]    n_resv,
  output logic [$clog2(DEPTH+1)-1:0]    n_avail,
  output logic                          full,
  output logic                          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(MAXWIN+1);
  localparam int CW = $clog2(DEPTH+1);

  typedef enum logic [2:0] {S_FREE, S_PRES, S_PHELD, S_AVAIL, S_CRES, S_CHELD} slot_e;

  slot_e          st   [DEPTH];
  slot_e          st_n [DEPTH];
  logic           wst  [DEPTH];
  logic           wst_n[DEPTH];
  logic [LW-1:0]  wlen [DEPTH];
  logic [LW-1:0]  wlen_n[DEPTH];
  logic [AW-1:0]  wr, rd, vis, fh;
  logic [AW-1:0]  wr_n, rd_n, vis_n, fh_n;

  logic p_ok, c_ok, p_lok, c_lok, p_cv, c_cv;
  logic [AW-1:0] p_at, c_at;

  assign p_lok = (p_len != '0) && (int'(p_len) <= MAXWIN);
  assign c_lok = (c_len != '0) && (int'(c_len) <= MAXWIN);

  always_comb begin
    logic okp, okc;
    p_ok = 1'b0; p_at = '0; c_ok = 1'b0; c_at = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      okp = 1'b1; okc = 1'b1;
      for (int k = 0; k < MAXWIN; k++) begin
        if (k < int'(p_len) && st[AW'(i+k)] != S_FREE)  okp = 1'b0;
        if (k < int'(c_len) && st[AW'(i+k)] != S_AVAIL) okc = 1'b0;
      end
      if (okp && (cfg_unordered || AW'(i) == wr)) begin p_ok = 1'b1; p_at = AW'(i); end
      if (okc && (cfg_unordered || AW'(i) == rd)) begin c_ok = 1'b1; c_at = AW'(i); end
    end
  end

  assign p_gnt  = p_req && p_lok && p_ok;
  assign p_ovf  = p_req && p_lok && !p_ok;
  assign p_base = p_at;
  assign c_gnt  = c_req && c_lok && c_ok;
  assign c_base = c_at;

  assign p_cv = p_cmt && wst[p_tag] && st[p_tag] == S_PRES;
  assign c_cv = c_cmt && wst[c_tag] && st[c_tag] == S_CRES;

  always_comb begin
    int  pc, cc;
    logic go;
    for (int i = 0; i < DEPTH; i++) begin
      st_n[i] = st[i]; wst_n[i] = wst[i]; wlen_n[i] = wlen[i];
    end
    if (p_cv) begin
      for (int k = 0; k < MAXWIN; k++)
        if (k < int'(wlen[p_tag])) st_n[AW'(int'(p_tag)+k)] = cfg_unordered ? S_AVAIL : S_PHELD;
      wst_n[p_tag] = 1'b0;
    end
    if (c_cv) begin
      for (int k = 0; k < MAXWIN; k++)
        if (k < int'(wlen[c_tag])) st_n[AW'(int'(c_tag)+k)] = cfg_unordered ? S_FREE : S_CHELD;
      wst_n[c_tag] = 1'b0;
    end
    if (p_gnt) begin
      for (int k = 0; k < MAXWIN; k++)
        if (k < int'(p_len)) st_n[AW'(int'(p_at)+k)] = S_PRES;
      wst_n[p_at] = 1'b1; wlen_n[p_at] = p_len;
    end
    if (c_gnt) begin
      for (int k = 0; k < MAXWIN; k++)
        if (k < int'(c_len)) st_n[AW'(int'(c_at)+k)] = S_CRES;
      wst_n[c_at] = 1'b1; wlen_n[c_at] = c_len;
    end
    pc = 0; go = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (go && st_n[AW'(int'(vis)+k)] == S_PHELD) begin
        st_n[AW'(int'(vis)+k)] = S_AVAIL; pc++;
      end else go = 1'b0;
    end
    cc = 0; go = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (go && st_n[AW'(int'(fh)+k)] == S_CHELD) begin
        st_n[AW'(int'(fh)+k)] = S_FREE; cc++;
      end else go = 1'b0;
    end
    vis_n = AW'(int'(vis) + pc);
    fh_n  = AW'(int'(fh) + cc);
    wr_n  = (p_gnt && !cfg_unordered) ? AW'(int'(wr) + int'(p_len)) : wr;
    rd_n  = (c_gnt && !cfg_unordered) ? AW'(int'(rd) + int'(c_len)) : rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i] <= S_FREE; wst[i] <= 1'b0; wlen[i] <= '0;
      end
      wr <= '0; rd <= '0; vis <= '0; fh <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i] <= st_n[i]; wst[i] <= wst_n[i]; wlen[i] <= wlen_n[i];
      end
      wr <= wr_n; rd <= rd_n; vis <= vis_n; fh <= fh_n;
    end
  end

  always_comb begin
    int nf, na;
    nf = 0; na = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (st[i] == S_FREE)  nf++;
      if (st[i] == S_AVAIL) na++;
    end
    n_free  = CW'(nf);
    n_avail = CW'(na);
    n_resv  = CW'(DEPTH - nf - na);
  end

  assign full  = (n_free == '0);
  assign empty = (n_avail == '0);

  a_r3_grant_or_overflow: assert property (@(posedge clk) disable iff (rst) !(p_gnt && p_ovf));
  a_r2_grant_fits:        assert property (@(posedge clk) disable iff (rst) p_gnt |-> int'(p_len) <= int'(n_free));
  a_r4_grant_fits:        assert property (@(posedge clk) disable iff (rst) c_gnt |-> int'(c_len) <= int'(n_avail));
  a_r9_full_refuses:      assert property (@(posedge clk) disable iff (rst) full |-> !p_gnt);
  a_r9_empty_refuses:     assert property (@(posedge clk) disable iff (rst) empty |-> !c_gnt);
  a_r5_avail_only_by_rsv: assert property (@(posedge clk) disable iff (rst) !c_gnt |=> n_avail >= $past(n_avail));
  a_r6_free_only_by_rsv:  assert property (@(posedge clk) disable iff (rst) !p_gnt |=> n_free >= $past(n_free));
endmodule

// File: tb/test_pkt_window_queue.sv
module test_pkt_window_queue;
  localparam int DEPTH = 8;
  localparam int MAXWIN = 4;

  typedef struct packed {
    logic       preq; logic [2:0] plen; logic pcmt; logic [2:0] ptag;
    logic       creq; logic [2:0] clen; logic ccmt; logic [2:0] ctag;
    logic       epg;  logic [2:0] epb;  logic eovf;
    logic       ecg;  logic [2:0] ecb;
    logic [3:0] efree; logic [3:0] eavail;
  } vec_t;

  // Ordered mode walk (R2 R3 R4 R5 R6 R7 R9 R10)
  localparam vec_t OV[17] = '{
    '{0,0,0,0, 0,0,0,0, 0,0,0, 0,0, 8,0},
    '{1,3,0,0, 0,0,0,0, 1,0,0, 0,0, 8,0},
    '{1,2,0,0, 0,0,0,0, 1,3,0, 0,0, 5,0},
    '{0,0,1,3, 0,0,0,0, 0,0,0, 0,0, 3,0},
    '{0,0,0,0, 1,1,0,0, 0,0,0, 0,0, 3,0},
    '{0,0,1,0, 0,0,0,0, 0,0,0, 0,0, 3,0},
    '{0,0,0,0, 1,2,0,0, 0,0,0, 1,0, 3,5},
    '{1,4,0,0, 1,3,0,0, 0,0,1, 1,2, 3,3},
    '{1,3,0,0, 0,0,1,2, 1,5,0, 0,0, 3,0},
    '{1,1,0,0, 0,0,1,0, 0,0,1, 0,0, 0,0},
    '{1,4,1,5, 0,0,0,0, 1,0,0, 0,0, 5,0},
    '{0,0,1,1, 1,4,0,0, 0,0,0, 0,0, 1,3},
    '{0,0,0,0, 1,3,0,0, 0,0,0, 1,5, 1,3},
    '{0,0,1,0, 0,0,0,0, 0,0,0, 0,0, 1,0},
    '{0,0,0,0, 0,0,1,5, 0,0,0, 0,0, 1,4},
    '{1,0,0,0, 1,0,0,0, 0,0,0, 0,0, 4,4},
    '{1,5,0,0, 0,0,0,0, 0,0,0, 0,0, 4,4}
  };

  // Unordered mode (R8)
  localparam vec_t UV[6] = '{
    '{1,2,0,0, 0,0,0,0, 1,0,0, 0,0, 8,0},
    '{1,2,0,0, 0,0,0,0, 1,2,0, 0,0, 6,0},
    '{0,0,1,2, 0,0,0,0, 0,0,0, 0,0, 4,0},
    '{0,0,0,0, 1,2,0,0, 0,0,0, 1,2, 4,2},
    '{0,0,0,0, 0,0,1,2, 0,0,0, 0,0, 4,0},
    '{1,3,0,0, 0,0,0,0, 1,2,0, 0,0, 6,0}
  };

  logic clk = 1'b0, rst = 1'b1, cfg_unordered = 1'b0;
  logic p_req = 0, p_cmt = 0, c_req = 0, c_cmt = 0;
  logic [2:0] p_len = 0, c_len = 0, p_tag = 0, c_tag = 0;
  logic p_gnt, p_ovf, c_gnt, full, empty;
  logic [2:0] p_base, c_base;
  logic [3:0] n_free, n_resv, n_avail;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pkt_window_queue #(.DEPTH(DEPTH), .MAXWIN(MAXWIN)) i_pkt_window_queue (
    .clk(clk), .rst(rst), .cfg_unordered(cfg_unordered),
    .p_req(p_req), .p_len(p_len), .p_gnt(p_gnt), .p_base(p_base), .p_ovf(p_ovf),
    .p_cmt(p_cmt), .p_tag(p_tag),
    .c_req(c_req), .c_len(c_len), .c_gnt(c_gnt), .c_base(c_base),
    .c_cmt(c_cmt), .c_tag(c_tag),
    .n_free(n_free), .n_resv(n_resv), .n_avail(n_avail), .full(full), .empty(empty));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input string req);
    @(negedge clk);
    p_req = v.preq; p_len = v.plen; p_cmt = v.pcmt; p_tag = v.ptag;
    c_req = v.creq; c_len = v.clen; c_cmt = v.ccmt; c_tag = v.ctag;
    #5;
    chk(req, "p_gnt", int'(p_gnt), int'(v.epg));
    if (v.epg) chk(req, "p_base", int'(p_base), int'(v.epb));
    chk(req, "p_ovf", int'(p_ovf), int'(v.eovf));
    chk(req, "c_gnt", int'(c_gnt), int'(v.ecg));
    if (v.ecg) chk(req, "c_base", int'(c_base), int'(v.ecb));
    chk(req, "n_free", int'(n_free), int'(v.efree));
    chk(req, "n_avail", int'(n_avail), int'(v.eavail));
    chk("R9", "n_resv", int'(n_resv), DEPTH - int'(v.efree) - int'(v.eavail));
    chk("R9", "full", int'(full), int'(v.efree == 0));
    chk("R9", "empty", int'(empty), int'(v.eavail == 0));
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; cfg_unordered = mode;
    p_req = 0; p_cmt = 0; c_req = 0; c_cmt = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    #5;
    chk("R1", "n_free", int'(n_free), DEPTH);
    chk("R1", "n_avail", int'(n_avail), 0);
    chk("R1", "n_resv", int'(n_resv), 0);
    chk("R1", "full", int'(full), 0);
    chk("R1", "empty", int'(empty), 1);
  endtask

  initial begin
    do_reset(1'b0);
    for (int i = 0; i < 17; i++) begin
      // v3/v4: R5 hold-back, v7/v9: R3 overflow, v8: R6 hold-back,
      // v10: R10 same-cycle reserve and commit, v11: R7 bogus tag, v15/v16: R3 bad lengths
      apply(OV[i], (i == 3 || i == 4 || i == 5) ? "R5" :
                   (i == 7 || i == 9 || i == 15 || i == 16) ? "R3" :
                   (i == 8 || i == 14) ? "R6" : (i == 10) ? "R10" :
                   (i == 11) ? "R7" : (i == 6 || i == 12) ? "R4" : "R2");
    end
    do_reset(1'b1);
    for (int i = 0; i < 6; i++) apply(UV[i], "R8");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule